// File: doc/BRIEF.md
# Transmit Queue with Write Holdoff

This block collects host writes aimed at shared memory and keeps them in order until they leave as outgoing network messages. Each stored entry is one word address, one data word and one interrupt flag. On the host side, a write is offered with a request and finishes when ready is high. A per-write keep bit lets an upstream filter finish a write without storing it. On the network side, the oldest entry is offered with valid and leaves when the consumer raises ready.

When the queue is full, a mode bit decides what happens to the next kept write. With the mode bit set, the host write cycle is held: ready stays low until an entry can leave. With the mode bit clear, ready stays high, the write is thrown away, and a saturating counter records the loss. Software can clear that counter with a one-cycle strobe. A full flag is exported so that a status register can show it as its bit 0. Turning entries into a serial network stream is done elsewhere.

Top module: `txq_holdoff_top`

## Requirements
- R1: Each entry carries a 21-bit word address, a 32-bit data word and a 1-bit interrupt flag. All three come out at the pop port exactly as they were written.
- R2: Entries leave in strict arrival order. `pop_valid` is high in the cycle after the first entry is stored and stays high while the queue is not empty.
- R3: `full` is registered. It goes high in the cycle after the queue holds DEPTH entries (1024 by default) and it implies `pop_valid`.
- R4: With `holdoff_en` high, the queue full, and no pop in the same cycle, `wr_ready` is low. A held write is neither stored nor counted as lost.
- R5: With `holdoff_en` high and the queue full, a pop in the same cycle raises `wr_ready`, and the write is stored behind the existing entries.
- R6: With `holdoff_en` low, `wr_ready` is always high. A kept write that arrives while the queue is full and nothing pops is discarded, and `lost_count` rises by one in the next cycle.
- R7: A kept write that meets a full queue in the same cycle as a pop is stored and does not change `lost_count`.
- R8: A write completed with `wr_keep` low is never stored and never counted as lost.
- R9: `lost_count` is 16 bits wide and holds at 65535 once it gets there.
- R10: `lost_clr` makes `lost_count` 0 in the next cycle and takes priority over a loss in the same cycle.
- R11: After reset the queue is empty, `full` is low and `lost_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| holdoff_en | input | 1 | 1: stall host writes on full; 0: drop them |
| lost_clr | input | 1 | One-cycle strobe that clears the lost-write counter |
| wr_req | input | 1 | Host write request |
| wr_keep | input | 1 | 1: store this write; 0: complete it without storing |
| wr_addr | input | 21 | Word address of the write |
| wr_data | input | 32 | Data word of the write |
| wr_irq | input | 1 | Interrupt flag of the write |
| wr_ready | output | 1 | The host write completes in this cycle |
| pop_valid | output | 1 | An entry is waiting at the pop port |
| pop_ready | input | 1 | The consumer takes the entry |
| pop_addr | output | 21 | Address of the oldest entry |
| pop_data | output | 32 | Data of the oldest entry |
| pop_irq | output | 1 | Interrupt flag of the oldest entry |
| full | output | 1 | The queue holds DEPTH entries |
| lost_count | output | 16 | Saturating count of discarded writes |

## Verification
A host write and a network pop can land in the same cycle while the queue is full. This is the case that decides whether the write is stored, held off or lost. The bench fills the queue to exactly 1024 entries. It then offers writes with the consumer idle, which must stall or drop them, and with the consumer ready, which must store them, in both modes. The second clash is a lost write in the same cycle as a counter clear, where the clear must win. The bench judges every case against its own occupancy model. It checks `wr_ready` within the cycle. It checks the counter and the stored order as entries drain, so that every entry must come out unchanged.

// File: rtl/txq_pkg.sv
// Package: shared widths and the entry record for the transmit queue.
// Assumes: address is a word address (byte bits dropped upstream).
package txq_pkg;
    localparam int ADDR_W = 21;
    localparam int DATA_W = 32;
    localparam int ENTRY_W = ADDR_W + DATA_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              irq;
    } txq_entry_t;
endpackage

// File: rtl/txq_store.sv
// Module: entry storage with one write port and one asynchronous read port.
// Assumes: the caller never writes and reads the same slot in a way that
// needs forwarding (a full queue reads the oldest slot, writes the freed one).
module txq_store
    import txq_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  txq_entry_t       wr_entry,
    input  logic [IDX_W-1:0] rd_idx,
    output txq_entry_t       rd_entry
);
    txq_entry_t slots [DEPTH];

    // Store an entry into its slot.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_idx] <= wr_entry;
        end
    end

    // Present the slot selected by the read index.
    always_comb begin
        rd_entry = slots[rd_idx];
    end
endmodule

// File: rtl/txq_ptrs.sv
// Module: read/write indices and occupancy of the circular store.
// Assumes: push is never raised on a full queue without a pop in the
// same cycle, and pop is never raised on an empty queue.
module txq_ptrs #(
    parameter int DEPTH = 1024,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic             full,
    output logic             nonempty
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);
    localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

    logic [CNT_W-1:0] occ;
    logic [IDX_W-1:0] wr_nxt;
    logic [IDX_W-1:0] rd_nxt;

    // Pick the wrap rule: free roll-over for powers of two, compare otherwise.
    generate
        if (POW2) begin : g_wrap_free
            always_comb begin
                wr_nxt = wr_idx + 1'b1;
                rd_nxt = rd_idx + 1'b1;
            end
        end else begin : g_wrap_cmp
            always_comb begin
                wr_nxt = (wr_idx == IDX_LAST) ? '0 : wr_idx + 1'b1;
                rd_nxt = (rd_idx == IDX_LAST) ? '0 : rd_idx + 1'b1;
            end
        end
    endgenerate

    // Advance indices and occupancy on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            rd_idx <= '0;
            occ    <= '0;
        end else begin
            if (push) begin
                wr_idx <= wr_nxt;
            end
            if (pop) begin
                rd_idx <= rd_nxt;
            end
            case ({push, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    // Derive the status flags from the occupancy register.
    always_comb begin
        full     = (occ == CNT_FULL);
        nonempty = (occ != '0);
    end
endmodule

// File: rtl/txq_admit.sv
// Module: decides per cycle whether a host write stalls, enters, or is lost.
// Assumes: full and pop_fire describe the same cycle as the write request.
module txq_admit (
    input  logic holdoff_en,
    input  logic full,
    input  logic pop_fire,
    input  logic wr_req,
    input  logic wr_keep,
    output logic wr_ready,
    output logic push,
    output logic drop
);
    logic no_room;
    logic taken;

    // Room exists unless full with no entry leaving this cycle.
    always_comb begin
        no_room  = full && !pop_fire;
        wr_ready = !(holdoff_en && no_room);
        taken    = wr_req && wr_ready && wr_keep;
        push     = taken && !no_room;
        drop     = taken && no_room;
    end
endmodule

// File: rtl/txq_lost_cnt.sv
// Module: saturating counter of discarded host writes.
// Assumes: clear has priority over an increment in the same cycle.
module txq_lost_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Clear, hold at the ceiling, or count one more loss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != CNT_MAX)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/txq_holdoff_top.sv
// Module: transmit queue for host shared-memory writes, with holdoff mode.
// Assumes: holdoff_en is a quasi-static control bit; the consumer may
// raise pop_ready at any time, and wr_ready depends on it combinationally.
module txq_holdoff_top
    import txq_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int LOST_W = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              holdoff_en,
    input  logic              lost_clr,
    input  logic              wr_req,
    input  logic              wr_keep,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_irq,
    output logic              wr_ready,
    output logic              pop_valid,
    input  logic              pop_ready,
    output logic [ADDR_W-1:0] pop_addr,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_irq,
    output logic              full,
    output logic [LOST_W-1:0] lost_count
);
    logic             push;
    logic             drop;
    logic             pop_fire;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    txq_entry_t       in_entry;
    txq_entry_t       out_entry;

    // Pack the host write and unpack the oldest entry.
    always_comb begin
        in_entry = '{addr: wr_addr, data: wr_data, irq: wr_irq};
        pop_fire = pop_valid && pop_ready;
        pop_addr = out_entry.addr;
        pop_data = out_entry.data;
        pop_irq  = out_entry.irq;
    end

    txq_admit u_admit (
        .holdoff_en (holdoff_en),
        .full       (full),
        .pop_fire   (pop_fire),
        .wr_req     (wr_req),
        .wr_keep    (wr_keep),
        .wr_ready   (wr_ready),
        .push       (push),
        .drop       (drop)
    );

    txq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop_fire),
        .wr_idx   (wr_idx),
        .rd_idx   (rd_idx),
        .full     (full),
        .nonempty (pop_valid)
    );

    txq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .wr_en    (push),
        .wr_idx   (wr_idx),
        .wr_entry (in_entry),
        .rd_idx   (rd_idx),
        .rd_entry (out_entry)
    );

    txq_lost_cnt #(.CNT_W(LOST_W)) u_lost (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (lost_clr),
        .inc   (drop),
        .count (lost_count)
    );
endmodule

// File: rtl/txq_holdoff_chk.sv
// Module: port-level properties of the transmit queue, bound to the top.
// Assumes: default LOST_W of 16 bits.
module txq_holdoff_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        holdoff_en,
    input logic        lost_clr,
    input logic        wr_req,
    input logic        wr_keep,
    input logic        wr_ready,
    input logic        pop_valid,
    input logic        pop_ready,
    input logic        full,
    input logic [15:0] lost_count
);
    AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> pop_valid); // R3
    AST_STALL_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (holdoff_en && full && !(pop_valid && pop_ready)) |-> !wr_ready); // R4
    AST_OPEN_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && pop_valid && pop_ready) |-> wr_ready); // R5
    AST_NO_STALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !holdoff_en |-> wr_ready); // R6
    AST_LOSS_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ready && wr_keep && full && !pop_ready && !lost_clr
         && lost_count != 16'hFFFF)
        |=> lost_count == 16'($past(lost_count) + 16'd1)); // R6
    AST_POP_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ready && pop_valid && pop_ready && !lost_clr)
        |=> $stable(lost_count)); // R7
    AST_FILTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ready && !wr_keep && !lost_clr) |=> $stable(lost_count)); // R8
    AST_LOST_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_count == 16'hFFFF && !lost_clr) |=> lost_count == 16'hFFFF); // R9
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        lost_clr |=> lost_count == 16'd0); // R10
endmodule

bind txq_holdoff_top txq_holdoff_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .holdoff_en (holdoff_en),
    .lost_clr   (lost_clr),
    .wr_req     (wr_req),
    .wr_keep    (wr_keep),
    .wr_ready   (wr_ready),
    .pop_valid  (pop_valid),
    .pop_ready  (pop_ready),
    .full       (full),
    .lost_count (lost_count)
);

// File: tb/txq_holdoff_top_test.sv
// Bench: scoreboard. The driver predicts each store into a queue; the
// monitor compares every popped entry against the front of that queue.
module txq_holdoff_top_test;
    localparam int DEPTH = 1024;
    localparam int LMAX = 65535;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        holdoff_en = 1'b0;
    logic        lost_clr = 1'b0;
    logic        wr_req = 1'b0;
    logic        wr_keep = 1'b0;
    logic [20:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wr_irq = 1'b0;
    logic        pop_ready = 1'b0;
    logic        wr_ready;
    logic        pop_valid;
    logic [20:0] pop_addr;
    logic [31:0] pop_data;
    logic        pop_irq;
    logic        full;
    logic [15:0] lost_count;

    int vectors = 0;
    int miscompares = 0;
    int mcount = 0;
    int mlost = 0;
    logic [53:0] sb [$];

    always #10 clk = ~clk;

    txq_holdoff_top uut (
        .clk(clk), .rst_n(rst_n), .holdoff_en(holdoff_en), .lost_clr(lost_clr),
        .wr_req(wr_req), .wr_keep(wr_keep), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_irq(wr_irq), .wr_ready(wr_ready), .pop_valid(pop_valid),
        .pop_ready(pop_ready), .pop_addr(pop_addr), .pop_data(pop_data),
        .pop_irq(pop_irq), .full(full), .lost_count(lost_count)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: one clock of stimulus, checks within the cycle, model update.
    task automatic step(input bit req, input bit keep, input logic [20:0] a,
                        input logic [31:0] d, input bit irq, input bit prdy,
                        input bit hold, input bit clr, input string tag);
        bit pf, fl, rdy, acc, psh, lst;
        @(posedge clk);
        #1;
        wr_req = req; wr_keep = keep; wr_addr = a; wr_data = d; wr_irq = irq;
        pop_ready = prdy; holdoff_en = hold; lost_clr = clr;
        #1;
        fl  = (mcount == DEPTH);
        pf  = prdy && (mcount > 0);
        rdy = !(hold && fl && !pf);
        acc = req && rdy;
        psh = acc && keep && (!fl || pf);
        lst = acc && keep && fl && !pf;
        chk(tag, "wr_ready", 64'(wr_ready), 64'(rdy));
        chk("R2", "pop_valid", 64'(pop_valid), 64'(mcount > 0));
        chk("R3", "full", 64'(full), 64'(fl));
        chk(tag, "lost_count", 64'(lost_count), 64'(mlost));
        if (pf) mcount--;
        if (psh) begin
            sb.push_back({a, d, irq});
            mcount++;
        end
        if (clr) mlost = 0;
        else if (lst && mlost < LMAX) mlost++;
    endtask

    // Monitor: compare each entry leaving the queue with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && pop_valid && pop_ready) begin
            if (sb.size() == 0) begin
                chk("R2", "pop from empty model", 64'(pop_data), 64'hDEAD);
            end else begin
                logic [53:0] e;
                e = sb.pop_front();
                chk("R1 R2", "pop entry", 64'({pop_addr, pop_data, pop_irq}), 64'(e));
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        vectors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #2;
        chk("R11", "pop_valid", 64'(pop_valid), 64'd0);
        chk("R11", "full", 64'(full), 64'd0);
        chk("R11", "lost_count", 64'(lost_count), 64'd0);
        chk("R11", "wr_ready", 64'(wr_ready), 64'd1);

        // R1 R2: mixed patterns with a consumer that stalls now and then.
        for (int i = 0; i < 40; i++)
            step(1'b1, 1'b1, 21'(i * 37 + 21'h1F0000), 32'hA5A50000 ^ (i * 32'h01010101),
                 i[0], (i % 3) == 0, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b1, 21'h1FFFFF, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b1, 21'h000000, 32'h00000000, 1'b0, 1'b1, 1'b0, 1'b0, "R1");
        for (int i = 0; i < 60; i++)
            step(1'b0, 1'b0, '0, '0, 1'b0, 1'b1, 1'b0, 1'b0, "R2");

        // R8: filtered writes on an empty queue leave nothing behind.
        for (int i = 0; i < 5; i++)
            step(1'b1, 1'b0, 21'(i), 32'(i), 1'b1, 1'b1, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b0, '0, '0, 1'b0, 1'b1, 1'b0, 1'b0, "R8");

        // R3: fill to exactly DEPTH entries with holdoff on.
        for (int i = 0; i < DEPTH; i++)
            step(1'b1, 1'b1, 21'(i * 3), 32'(i) * 32'h9E3779B1, i[2], 1'b0, 1'b1, 1'b0, "R3");

        // R4: held writes while full and no pop.
        for (int i = 0; i < 4; i++)
            step(1'b1, 1'b1, 21'h0ABCDE, 32'h12345678, 1'b1, 1'b0, 1'b1, 1'b0, "R4");
        // R5: pop in the same cycle lets the held write in.
        step(1'b1, 1'b1, 21'h0ABCDE, 32'h12345678, 1'b1, 1'b1, 1'b1, 1'b0, "R5");
        step(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0, "R4");

        // R6: holdoff off, full, no pop: writes are lost and counted.
        for (int i = 0; i < 3; i++)
            step(1'b1, 1'b1, 21'h111111, 32'h0BADF00D, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
        // R7: full with a pop in the same cycle: stored, not lost.
        step(1'b1, 1'b1, 21'h0C0FFE, 32'hCAFEF00D, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
        // R8: filtered write on a full queue is not counted.
        step(1'b1, 1'b0, 21'h1, 32'h1, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
        // R10: clear in the same cycle as a loss wins.
        step(1'b1, 1'b1, 21'h2, 32'h2, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
        step(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R10");

        // R9: drive the counter past its ceiling.
        for (int i = 0; i < LMAX + 4; i++)
            step(1'b1, 1'b1, 21'h3, 32'h3, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
        step(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
        step(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
        step(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R10");

        // R2: drain everything and confirm order end to end.
        for (int i = 0; i < DEPTH + 8; i++)
            step(1'b0, 1'b0, '0, '0, 1'b0, 1'b1, 1'b0, 1'b0, "R2");
        chk("R2", "scoreboard empty", 64'(sb.size()), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule